// File: doc/BRIEF.md
# Pointer Adjustment Test Sequencer

This block produces the timing of pointer adjustment events used to stress a path terminating demultiplexer. It counts frame ticks (one per 125 µs frame) and, after a start pulse, walks through an initialization phase, a cooling-down phase and a programmable number of measurement phases. During that run it raises a one-cycle adjustment strobe at the instants demanded by the selected pattern. All strobes of a run carry the same polarity, and the block returns to idle with a done pulse after the last measurement phase.

Four patterns are offered. Two are isolated: one adjustment, or a burst of three closely spaced adjustments, in the middle of every measurement phase. Two are periodic: a background of adjustments at a programmable spacing of T ticks, in which each cycle of 90 slots carries an adjustment in its first 87 slots and none in its last 3. The perturbed variant also adds or removes exactly one adjustment once per measurement phase. All durations are frame-tick counts set by parameters (defaults: 1 s initialization, 30 s cooling-down, 30 s per measurement phase, 4-tick burst gap). The rewriting of pointer bytes and the mapping of the payload are done elsewhere.

Top module: `ptr_adj_seq`

## Requirements
- R1: After reset, phase_o is 0 (idle) and adj_strobe_o, done_o and meas_win_o are 0.
- R2: A start pulse in idle latches the configuration. The block then spends INIT_TICKS ticks with phase_o=1, COOL_TICKS ticks with phase_o=2, and then the measurement phases of PHASE_TICKS ticks each with phase_o=3. meas_win_o is high exactly while phase_o is 3.
- R3: The number of measurement phases is cfg_meas_i, except that 0 gives one phase and values above MAX_MEAS give MAX_MEAS phases.
- R4: In the cycle after the final tick of the last measurement phase, done_o is high for one cycle and phase_o is 0 again.
- R5: Mode 0 (single) gives exactly one strobe per measurement phase, on the tick whose index within the phase is PHASE_TICKS/2, and no strobe during initialization or cooling-down.
- R6: Mode 1 (burst) gives three strobes per measurement phase, on phase-tick indices PHASE_TICKS/2, PHASE_TICKS/2+BURST_GAP and PHASE_TICKS/2+2*BURST_GAP.
- R7: Modes 2 (periodic) and 3 (perturbed) count ticks j from the first cooling-down tick. The background strobe falls on every tick with j mod T = T-1 whose slot number floor(j/T) mod 90 is below 87, through cooling-down and all measurement phases. No strobe falls in initialization.
- R8: In mode 3 with cfg_cancel_i=1, each measurement phase removes the first background strobe that falls at or after phase-tick index PHASE_TICKS/2.
- R9: In mode 3 with cfg_cancel_i=0, each measurement phase adds one strobe on the first tick at or after phase-tick index PHASE_TICKS/2 with j mod T = T/2-1, midway through a slot. This tick never coincides with a background strobe.
- R10: adj_pol_o equals the cfg_pol_i latched at start and does not change during a run.
- R11: Start pulses and configuration changes during a run have no effect on that run.
- R12: Each strobe is one cycle wide and appears in the cycle after the frame tick it belongs to. Ticks in idle produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Frame tick, one cycle wide |
| start_i | input | 1 | Starts a run when idle |
| cfg_mode_i | input | 2 | 0 single, 1 burst, 2 periodic, 3 perturbed |
| cfg_spacing_i | input | SPACING_W | Background spacing T in ticks, values below 2 taken as 2 |
| cfg_cancel_i | input | 1 | Perturbation type: 1 cancel, 0 add |
| cfg_pol_i | input | 1 | Adjustment polarity for the whole run |
| cfg_meas_i | input | MEAS_W | Number of measurement phases |
| adj_strobe_o | output | 1 | Adjustment event strobe |
| adj_pol_o | output | 1 | Polarity of the adjustments |
| phase_o | output | 2 | 0 idle, 1 init, 2 cool, 3 measurement |
| meas_win_o | output | 1 | High during measurement phases |
| done_o | output | 1 | One-cycle pulse at the end of the run |

## Verification
A corrupted phase or tick counter shows up on phase_o at the next phase boundary, and for the isolated modes it also moves the mid-phase strobes within the same phase. A wrong slot counter shifts a background strobe or the 3-slot gap within one slot of T ticks, at the latest one 90-slot cycle later. A stale perturbation flag shows up as a missing or extra strobe in the first slot after the middle of a measurement phase. A wrong measurement counter shows up on done_o and phase_o at the end of the run.

// File: rtl/ptr_adj_seq_pkg.sv
package ptr_adj_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_COOL = 2'd2,
    PH_MEAS = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    MD_SINGLE   = 2'd0,
    MD_BURST    = 2'd1,
    MD_PERIODIC = 2'd2,
    MD_PERTURB  = 2'd3
  } mode_e;
endpackage

// File: rtl/ptr_adj_seq_phase.sv
module ptr_adj_seq_phase
  import ptr_adj_seq_pkg::*;
#(
  parameter int INIT_TICKS  = 8000,
  parameter int COOL_TICKS  = 240000,
  parameter int PHASE_TICKS = 240000,
  parameter int MEAS_W      = 4,
  parameter int CNT_W       = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [MEAS_W-1:0] meas_total_i,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  pc_o,
  output logic              last_o,
  output logic              run_o,
  output logic              done_o
);
  phase_e             phase_q;
  logic [CNT_W-1:0]   pc_q;
  logic [MEAS_W-1:0]  meas_q;
  logic [CNT_W-1:0]   len;
  logic               done_q;

  always_comb begin
    case (phase_q)
      PH_INIT: len = CNT_W'(INIT_TICKS);
      PH_COOL: len = CNT_W'(COOL_TICKS);
      default: len = CNT_W'(PHASE_TICKS);
    endcase
  end

  assign run_o  = tick_i && (phase_q != PH_IDLE);
  assign last_o = (pc_q == len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pc_q    <= '0;
      meas_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          phase_q <= PH_INIT;
          pc_q    <= '0;
          meas_q  <= '0;
        end
      end else if (tick_i) begin
        if (last_o) begin
          pc_q <= '0;
          case (phase_q)
            PH_INIT: phase_q <= PH_COOL;
            PH_COOL: begin
              phase_q <= PH_MEAS;
              meas_q  <= '0;
            end
            default: begin
              if (meas_q == meas_total_i - MEAS_W'(1)) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end else begin
                meas_q <= meas_q + MEAS_W'(1);
              end
            end
          endcase
        end else begin
          pc_q <= pc_q + CNT_W'(1);
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign pc_o    = pc_q;
  assign done_o  = done_q;
endmodule

// File: rtl/ptr_adj_seq_slots.sv
module ptr_adj_seq_slots #(
  parameter int SPACING_W   = 16,
  parameter int ON_SLOTS    = 87,
  parameter int CYCLE_SLOTS = 90
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic                 adv_i,
  input  logic [SPACING_W-1:0] spacing_i,
  output logic                 end_fire_o,
  output logic                 mid_fire_o
);
  localparam int IDX_W = $clog2(CYCLE_SLOTS);

  logic [SPACING_W-1:0] timer_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 slot_end;

  assign slot_end   = (timer_q == spacing_i - SPACING_W'(1));
  assign end_fire_o = adv_i && slot_end && (idx_q < IDX_W'(ON_SLOTS));
  assign mid_fire_o = adv_i && (timer_q == (spacing_i >> 1) - SPACING_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      timer_q <= '0;
      idx_q   <= '0;
    end else if (adv_i) begin
      if (slot_end) begin
        timer_q <= '0;
        idx_q   <= (idx_q == IDX_W'(CYCLE_SLOTS - 1)) ? '0 : idx_q + IDX_W'(1);
      end else begin
        timer_q <= timer_q + SPACING_W'(1);
      end
    end
  end
endmodule

// File: rtl/ptr_adj_seq_events.sv
module ptr_adj_seq_events
  import ptr_adj_seq_pkg::*;
#(
  parameter int PHASE_TICKS = 240000,
  parameter int BURST_GAP   = 4,
  parameter int CNT_W       = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             run_i,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] pc_i,
  input  logic             last_i,
  input  mode_e            mode_i,
  input  logic             cancel_i,
  input  logic             bg_end_i,
  input  logic             bg_mid_i,
  output logic             strobe_o
);
  localparam int MID = PHASE_TICKS / 2;

  logic in_meas, at_mid, armed_q, pending, hit_cancel, hit_add, perturb;
  logic [CNT_W-1:0] burst_pos [3];

  for (genvar b = 0; b < 3; b++) begin : g_burst
    assign burst_pos[b] = CNT_W'(MID + b * BURST_GAP);
  end

  assign in_meas    = (phase_i == PH_MEAS);
  assign at_mid     = in_meas && (pc_i == burst_pos[0]);
  assign perturb    = (mode_i == MD_PERTURB);
  assign pending    = perturb && (armed_q || at_mid);
  assign hit_cancel = pending && cancel_i && bg_end_i;
  assign hit_add    = pending && !cancel_i && bg_mid_i;

  always_comb begin
    case (mode_i)
      MD_SINGLE:   strobe_o = at_mid;
      MD_BURST:    strobe_o = in_meas && ((pc_i == burst_pos[0]) ||
                                          (pc_i == burst_pos[1]) ||
                                          (pc_i == burst_pos[2]));
      MD_PERIODIC: strobe_o = bg_end_i;
      default:     strobe_o = (bg_end_i && !hit_cancel) || hit_add;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      armed_q <= 1'b0;
    end else if (run_i) begin
      if (last_i || hit_cancel || hit_add) armed_q <= 1'b0;
      else if (perturb && at_mid)          armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ptr_adj_seq.sv
module ptr_adj_seq
  import ptr_adj_seq_pkg::*;
#(
  parameter int INIT_TICKS  = 8000,
  parameter int COOL_TICKS  = 240000,
  parameter int PHASE_TICKS = 240000,
  parameter int BURST_GAP   = 4,
  parameter int SPACING_W   = 16,
  parameter int MAX_MEAS    = 10,
  parameter int ON_SLOTS    = 87,
  parameter int CYCLE_SLOTS = 90,
  localparam int MEAS_W     = $clog2(MAX_MEAS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 start_i,
  input  logic [1:0]           cfg_mode_i,
  input  logic [SPACING_W-1:0] cfg_spacing_i,
  input  logic                 cfg_cancel_i,
  input  logic                 cfg_pol_i,
  input  logic [MEAS_W-1:0]    cfg_meas_i,
  output logic                 adj_strobe_o,
  output logic                 adj_pol_o,
  output logic [1:0]           phase_o,
  output logic                 meas_win_o,
  output logic                 done_o
);
  localparam int MAXLEN_A = (INIT_TICKS > COOL_TICKS) ? INIT_TICKS : COOL_TICKS;
  localparam int MAXLEN   = (MAXLEN_A > PHASE_TICKS) ? MAXLEN_A : PHASE_TICKS;
  localparam int CNT_W    = $clog2(MAXLEN + 1);

  phase_e               phase;
  logic [CNT_W-1:0]     pc;
  logic                 last, run, accept, adv, bg_end, bg_mid, ev_strobe;
  mode_e                mode_q;
  logic [SPACING_W-1:0] spacing_q;
  logic                 cancel_q, pol_q, strobe_q;
  logic [MEAS_W-1:0]    meas_q;

  assign accept = start_i && (phase == PH_IDLE);
  assign adv    = run && ((phase == PH_COOL) || (phase == PH_MEAS));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MD_SINGLE;
      spacing_q <= SPACING_W'(2);
      cancel_q  <= 1'b0;
      pol_q     <= 1'b0;
      meas_q    <= MEAS_W'(1);
    end else if (accept) begin
      mode_q    <= mode_e'(cfg_mode_i);
      spacing_q <= (cfg_spacing_i < SPACING_W'(2)) ? SPACING_W'(2) : cfg_spacing_i;
      cancel_q  <= cfg_cancel_i;
      pol_q     <= cfg_pol_i;
      if (cfg_meas_i == '0)                      meas_q <= MEAS_W'(1);
      else if (cfg_meas_i > MEAS_W'(MAX_MEAS))   meas_q <= MEAS_W'(MAX_MEAS);
      else                                       meas_q <= cfg_meas_i;
    end
  end

  ptr_adj_seq_phase #(
    .INIT_TICKS(INIT_TICKS), .COOL_TICKS(COOL_TICKS), .PHASE_TICKS(PHASE_TICKS),
    .MEAS_W(MEAS_W), .CNT_W(CNT_W)
  ) phase_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i),
    .meas_total_i(meas_q), .phase_o(phase), .pc_o(pc), .last_o(last),
    .run_o(run), .done_o(done_o)
  );

  ptr_adj_seq_slots #(
    .SPACING_W(SPACING_W), .ON_SLOTS(ON_SLOTS), .CYCLE_SLOTS(CYCLE_SLOTS)
  ) slots_i (
    .clk(clk), .rst(rst), .clear_i(accept), .adv_i(adv), .spacing_i(spacing_q),
    .end_fire_o(bg_end), .mid_fire_o(bg_mid)
  );

  ptr_adj_seq_events #(
    .PHASE_TICKS(PHASE_TICKS), .BURST_GAP(BURST_GAP), .CNT_W(CNT_W)
  ) events_i (
    .clk(clk), .rst(rst), .clear_i(accept), .run_i(run), .phase_i(phase),
    .pc_i(pc), .last_i(last), .mode_i(mode_q), .cancel_i(cancel_q),
    .bg_end_i(bg_end), .bg_mid_i(bg_mid), .strobe_o(ev_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= run && ev_strobe;
  end

  assign adj_strobe_o = strobe_q;
  assign adj_pol_o    = pol_q;
  assign phase_o      = phase;
  assign meas_win_o   = (phase == PH_MEAS);
endmodule

// File: rtl/ptr_adj_seq_chk.sv
module ptr_adj_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic [1:0] phase_o,
  input logic       adj_strobe_o,
  input logic       adj_pol_o,
  input logic       meas_win_o,
  input logic       done_o
);
  // R12: a strobe always follows a frame tick
  assert_strobe_after_tick_R12: assert property (@(posedge clk) disable iff (rst)
    adj_strobe_o |-> $past(tick_i));

  // R7: no strobe belongs to an initialization or idle tick
  assert_no_strobe_in_init_R7: assert property (@(posedge clk) disable iff (rst)
    adj_strobe_o |-> ($past(phase_o) == 2'd2 || $past(phase_o) == 2'd3));

  // R4: done comes out of the last measurement phase and lands in idle
  assert_done_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (phase_o == 2'd0 && $past(phase_o) == 2'd3));

  // R10: polarity is steady inside a run
  assert_pol_steady_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 2'd0 && $past(phase_o) != 2'd0) |-> $stable(adj_pol_o));

  // R11: a run only begins from idle
  assert_start_only_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd1 && $past(phase_o) != 2'd1) |-> $past(phase_o) == 2'd0);

  // R2: the measurement window opens only after cooling-down
  assert_win_after_cool_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_win_o) |-> $past(phase_o) == 2'd2);
endmodule

bind ptr_adj_seq ptr_adj_seq_chk chk_i (
  .clk(clk), .rst(rst), .tick_i(tick_i), .phase_o(phase_o),
  .adj_strobe_o(adj_strobe_o), .adj_pol_o(adj_pol_o),
  .meas_win_o(meas_win_o), .done_o(done_o)
);

// File: tb/ptr_adj_seq_tb_top.sv
module ptr_adj_seq_tb_top;
  localparam int INIT_T = 20;
  localparam int COOL_T = 200;
  localparam int PHASE_T = 600;
  localparam int GAP = 4;
  localparam int MID = PHASE_T / 2;
  localparam int MAXM = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cfg_mode_i = 2'd0;
  logic [15:0] cfg_spacing_i = 16'd2;
  logic        cfg_cancel_i = 1'b0;
  logic        cfg_pol_i = 1'b0;
  logic [3:0]  cfg_meas_i = 4'd1;
  logic        adj_strobe_o, adj_pol_o, meas_win_o, done_o;
  logic [1:0]  phase_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ptr_adj_seq #(
    .INIT_TICKS(INIT_T), .COOL_TICKS(COOL_T), .PHASE_TICKS(PHASE_T),
    .BURST_GAP(GAP), .SPACING_W(16), .MAX_MEAS(MAXM)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i),
    .cfg_mode_i(cfg_mode_i), .cfg_spacing_i(cfg_spacing_i),
    .cfg_cancel_i(cfg_cancel_i), .cfg_pol_i(cfg_pol_i), .cfg_meas_i(cfg_meas_i),
    .adj_strobe_o(adj_strobe_o), .adj_pol_o(adj_pol_o), .phase_o(phase_o),
    .meas_win_o(meas_win_o), .done_o(done_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_phase(int k, int nm);
    if (k < INIT_T) return 1;
    if (k < INIT_T + COOL_T) return 2;
    if (k < INIT_T + COOL_T + nm * PHASE_T) return 3;
    return 0;
  endfunction

  function automatic int eff_meas(int m);
    if (m == 0) return 1;
    if (m > MAXM) return MAXM;
    return m;
  endfunction

  function automatic string ev_tag(int mode, int cancel);
    case (mode)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return cancel ? "R8" : "R9";
    endcase
  endfunction

  // One full run; expected strobes come from the pattern rules
  task automatic run_seq(int mode, int t, int cancel, int pol, int meas, string ph_tag);
    int nm = eff_meas(meas);
    int total = INIT_T + COOL_T + nm * PHASE_T;
    int armed = 0;
    int nstrobe = 0;
    int nexp = 0;
    @(negedge clk);
    cfg_mode_i = 2'(mode); cfg_spacing_i = 16'(t); cfg_cancel_i = 1'(cancel);
    cfg_pol_i = 1'(pol); cfg_meas_i = 4'(meas); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < total; k++) begin
      int ph = exp_phase(k, nm);
      int j = k - INIT_T;
      int pc = (ph == 3) ? (k - INIT_T - COOL_T) % PHASE_T : -1;
      int bg_end = (ph >= 2) && (j % t == t - 1) && ((j / t) % 90 < 87);
      int bg_mid = (ph >= 2) && (j % t == t / 2 - 1);
      int mid = (ph == 3) && (pc == MID);
      int pend, e;
      if (ph == 3 && pc == 0) armed = 0;
      pend = armed || mid;
      case (mode)
        0: e = mid;
        1: e = (ph == 3) && (pc == MID || pc == MID + GAP || pc == MID + 2 * GAP);
        2: e = bg_end;
        default: begin
          if (cancel != 0 && pend && bg_end) begin e = 0; armed = 0; end
          else if (cancel == 0 && pend && bg_mid) begin e = 1; armed = 0; end
          else begin e = bg_end; if (mid) armed = 1; end
        end
      endcase
      if (k == 41) begin
        start_i = 1'b0;
        cfg_mode_i = 2'(mode); cfg_spacing_i = 16'(t); cfg_cancel_i = 1'(cancel);
        cfg_pol_i = 1'(pol); cfg_meas_i = 4'(meas);
      end
      chk((k == 41) ? "R11" : ph_tag, int'(phase_o), ph);
      chk("R2", int'(meas_win_o), (ph == 3) ? 1 : 0);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      chk(ev_tag(mode, cancel), int'(adj_strobe_o), e);
      if (adj_strobe_o) begin
        nstrobe++;
        chk("R10", int'(adj_pol_o), pol);
      end
      nexp += e;
      chk("R4", int'(done_o), (k == total - 1) ? 1 : 0);
      if (k == 40) begin
        // disturbance while running: must have no effect
        start_i = 1'b1;
        cfg_mode_i = 2'($urandom_range(0, 3)); cfg_spacing_i = 16'($urandom_range(2, 40));
        cfg_cancel_i = 1'($urandom_range(0, 1)); cfg_pol_i = ~1'(pol);
        cfg_meas_i = 4'($urandom_range(1, 3));
      end
      @(negedge clk);
      chk("R12", int'(adj_strobe_o), 0);
    end
    chk(ph_tag, int'(phase_o), 0);
    chk(ev_tag(mode, cancel), nstrobe, nexp);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(phase_o), 0);
    chk("R1", int'(adj_strobe_o), 0);
    chk("R1", int'(done_o), 0);
    chk("R1", int'(meas_win_o), 0);
    // ticks in idle do nothing
    for (int i = 0; i < 6; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      chk("R12", int'(adj_strobe_o), 0);
      chk("R12", int'(phase_o), 0);
      @(negedge clk);
    end
    run_seq(0, 2, 0, 1, 2, "R2");
    run_seq(1, 2, 0, 0, 2, "R2");
    run_seq(2, 3, 0, 1, 2, "R2");
    run_seq(3, 7, 1, 0, 3, "R2");
    run_seq(3, 2, 0, 1, 2, "R2");
    run_seq(3, 5, 0, 0, 0, "R3");
    run_seq(2, 3, 0, 0, 15, "R3");
    for (int r = 0; r < 3; r++) begin
      run_seq($urandom_range(0, 3), $urandom_range(2, 13), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(1, 2), "R2");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule